// File: doc/BRIEF.md
# Dynamic Bus Sizing Bridge

This block sits between a 32-bit synchronous processor bus and a peripheral port whose data width is not fixed. The port reports its width on every cycle through a pair of active-low size acknowledge lines. When chip select is seen on a rising clock edge, the bridge captures the byte offset, the size code, the direction and, for writes, all 32 bits of write data. It then runs as many peripheral cycles as the reported width requires to cover the requested bytes.

For each peripheral cycle the bridge drives a local byte address, a remaining-byte count, a direction line and a data strobe. It holds these until the port acknowledges. Narrow ports sit on the most significant byte lanes. On reads, each acknowledged cycle writes its bytes into a 32-bit assembly register, and that register drives the processor read bus. A one-cycle transfer acknowledge ends the access. The bridge then waits for chip select to fall before it accepts another access.

Top module: `dbs_bridge`

## Requirements
- R1: While rst_ni is low, ta_o and pstb_o are 0 whatever cs_i does.
- R2: When cs_i is 1 on a rising edge in the idle state, the access is recognised on that edge. pstb_o is 1 in the following cycle, with pa_o equal to the captured addr_i and pwr_o equal to the inverse of the captured rnw_i.
- R3: pack_ni is active low. 2'b00 means a 32-bit port, 2'b01 a 16-bit port, 2'b10 an 8-bit port and 2'b11 wait. While pack_ni is 2'b11 on a rising edge with pstb_o high, pstb_o stays high and pa_o and psiz_o do not change.
- R4: Byte 0 is bits 31:24 and byte 3 is bits 7:0. After an acknowledge of port width P bytes at address c, the next cycle address is c rounded down to a multiple of P, plus P. Cycles continue until every requested byte is covered, so the number of strobes equals the number of distinct P-aligned windows that the requested bytes touch.
- R5: On reads, requested byte b is taken from peripheral lane (b mod P) of pdata_i in the cycle that covers it. Bytes outside the request read as zero on rdata_o.
- R6: Write data and the transfer controls are captured on the recognising edge, and later changes on wdata_i, addr_i, size_i and rnw_i have no effect. With c the current pa_o, pdata_o carries write byte c on lane 0, byte (c with bit 0 set) on lane 1, and bytes 2 and 3 on lanes 2 and 3.
- R7: psiz_o gives the number of requested bytes from pa_o to the last requested byte, modulo 4. The value 0 means four.
- R8: After each acknowledged cycle pstb_o is low for at least one clock before the next strobe or the acknowledge.
- R9: ta_o is high for exactly one cycle, in the cycle after the final acknowledged strobe. rdata_o is valid while ta_o is high.
- R10: After ta_o, no strobe and no further ta_o occur until cs_i has been sampled low.
- R11: The size codes are 2'b01 for one byte, 2'b10 for two bytes, and 2'b00 or 2'b11 for four bytes. The span runs from addr_i and is clipped at byte 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, held for the whole access |
| addr_i | input | 2 | Byte offset of the access |
| size_i | input | 2 | Size code |
| rnw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 32 | Processor write data |
| rdata_o | output | 32 | Assembled read data |
| ta_o | output | 1 | Transfer acknowledge, one-cycle pulse |
| pa_o | output | 2 | Peripheral byte address |
| psiz_o | output | 2 | Remaining byte count, 0 = four |
| pwr_o | output | 1 | Peripheral write cycle |
| pstb_o | output | 1 | Peripheral data strobe |
| pdata_o | output | 32 | Steered write data |
| pdata_i | input | 32 | Peripheral read data |
| pack_ni | input | 2 | Port size acknowledge, active low |

## Verification
The hardest case to reach is a multi-cycle access in which the address walk is irregular. This happens with a misaligned start on a 16-bit port, where the first cycle covers only the odd byte of a window, and with wait states mixed in. The processor inputs are also scrambled right after recognition. A peripheral model in the bench chooses the port width for each access and inserts random stalls before each acknowledge. Directed sweeps cover every offset, size code, direction and width, and random accesses follow.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_STB, ST_GAP, ST_DONE, ST_HOLD} seq_state_e;

  localparam logic [1:0] ACK_W32  = 2'b00;
  localparam logic [1:0] ACK_W16  = 2'b01;
  localparam logic [1:0] ACK_W8   = 2'b10;
  localparam logic [1:0] ACK_WAIT = 2'b11;

  // last requested byte, clipped to the top lane
  function automatic logic [1:0] span_last(input logic [1:0] a, input logic [1:0] siz);
    logic [2:0] e;
    case (siz)
      2'b01:   e = {1'b0, a};
      2'b10:   e = {1'b0, a} + 3'd1;
      default: e = {1'b0, a} + 3'd3;
    endcase
    return (e > 3'd3) ? 2'd3 : e[1:0];
  endfunction
endpackage

// File: rtl/dbs_span.sv
module dbs_span
  import dbs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 2
) (
  input  logic [AW-1:0]       cur_i,
  input  logic [AW-1:0]       last_i,
  input  logic [1:0]          ack_ni,
  output logic                ack_vld_o,
  output logic                fin_o,
  output logic [AW-1:0]       next_o,
  output logic [AW-1:0]       remain_o,
  output logic [LANES-1:0]    take_o,
  output logic [LANES*AW-1:0] sel_o
);
  logic [AW-1:0] pmask, base, hi, top;
  logic [AW:0]   nxt;
  logic [LANES:0] above;

  always_comb begin
    ack_vld_o = (ack_ni != ACK_WAIT);
    case (ack_ni)
      ACK_W32: pmask = '1;
      ACK_W16: pmask = AW'(1);
      default: pmask = '0;
    endcase
    base     = cur_i & ~pmask;
    hi       = base | pmask;
    nxt      = {1'b0, base} + {1'b0, pmask} + (AW+1)'(1);
    fin_o    = nxt > {1'b0, last_i};
    next_o   = nxt[AW-1:0];
    remain_o = last_i - cur_i + AW'(1);
    top      = (last_i < hi) ? last_i : hi;
    above    = {(LANES+1){1'b1}} << ({1'b0, top} + (AW+1)'(1));
    take_o   = ({LANES{1'b1}} << cur_i) & ~above[LANES-1:0] & {LANES{ack_vld_o}};
  end

  for (genvar b = 0; b < LANES; b++) begin : g_sel
    assign sel_o[b*AW +: AW] = AW'(b) & pmask;
  end
endmodule

// File: rtl/dbs_lanes.sv
module dbs_lanes #(
  parameter int DW    = 32,
  parameter int LANES = 4,
  parameter int AW    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [AW-1:0]       cur_i,
  input  logic [LANES-1:0]    take_i,
  input  logic [LANES*AW-1:0] sel_i,
  input  logic [DW-1:0]       pdata_i,
  output logic [DW-1:0]       pdata_o,
  output logic [DW-1:0]       rdata_o
);
  logic [DW-1:0] wbuf_q, rbuf_q;

  function automatic logic [7:0] pick_lane(input logic [DW-1:0] d, input logic [AW-1:0] i);
    return d[DW-1-8*int'(i) -: 8];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wbuf_q <= '0;
    else if (load_i) wbuf_q <= wdata_i;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rbuf_q[DW-1-8*b -: 8] <= '0;
      else if (load_i)    rbuf_q[DW-1-8*b -: 8] <= '0;
      else if (take_i[b]) rbuf_q[DW-1-8*b -: 8] <= pick_lane(pdata_i, sel_i[b*AW +: AW]);
    end
  end

  // lane 0 serves byte ports, lane 1 the odd byte of word ports
  for (genvar l = 0; l < LANES; l++) begin : g_wr
    logic [AW-1:0] src;
    if (l == 0) begin : g_l0
      assign src = cur_i;
    end else if (l == 1) begin : g_l1
      assign src = {cur_i[AW-1:1], 1'b1};
    end else begin : g_ln
      assign src = AW'(l);
    end
    assign pdata_o[DW-1-8*l -: 8] = pick_lane(wbuf_q, src);
  end

  assign rdata_o = rbuf_q;
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          rnw_i,
  input  logic          ack_vld_i,
  input  logic          fin_i,
  input  logic [AW-1:0] next_i,
  output logic          load_o,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] last_o,
  output logic          rnw_o,
  output logic          pstb_o,
  output logic          ta_o,
  output logic          cap_en_o
);
  seq_state_e    state_q;
  logic [AW-1:0] cur_q, last_q;
  logic          rnw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      rnw_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (cs_i) begin
          cur_q   <= addr_i;
          last_q  <= AW'(span_last(addr_i, size_i));
          rnw_q   <= rnw_i;
          state_q <= ST_STB;
        end
        ST_STB: if (ack_vld_i) begin
          if (fin_i) state_q <= ST_DONE;
          else begin
            cur_q   <= next_i;
            state_q <= ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_STB;
        ST_DONE: state_q <= ST_HOLD;
        ST_HOLD: if (!cs_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = (state_q == ST_IDLE) && cs_i;
  assign cur_o    = cur_q;
  assign last_o   = last_q;
  assign rnw_o    = rnw_q;
  assign pstb_o   = (state_q == ST_STB);
  assign ta_o     = (state_q == ST_DONE);
  assign cap_en_o = (state_q == ST_STB) && rnw_q;
endmodule

// File: rtl/dbs_bridge.sv
module dbs_bridge #(
  parameter int DW = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_i,
  input  logic [$clog2(DW/8)-1:0]    addr_i,
  input  logic [1:0]                 size_i,
  input  logic                       rnw_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       ta_o,
  output logic [$clog2(DW/8)-1:0]    pa_o,
  output logic [1:0]                 psiz_o,
  output logic                       pwr_o,
  output logic                       pstb_o,
  output logic [DW-1:0]              pdata_o,
  input  logic [DW-1:0]              pdata_i,
  input  logic [1:0]                 pack_ni
);
  localparam int LANES = DW / 8;
  localparam int AW    = $clog2(LANES);

  logic                ack_vld, fin, load, rnw_q, cap_en;
  logic [AW-1:0]       next_a, cur_a, last_a, remain;
  logic [LANES-1:0]    take;
  logic [LANES*AW-1:0] sel;

  dbs_seq #(.AW(AW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .addr_i   (addr_i),
    .size_i   (size_i),
    .rnw_i    (rnw_i),
    .ack_vld_i(ack_vld),
    .fin_i    (fin),
    .next_i   (next_a),
    .load_o   (load),
    .cur_o    (cur_a),
    .last_o   (last_a),
    .rnw_o    (rnw_q),
    .pstb_o   (pstb_o),
    .ta_o     (ta_o),
    .cap_en_o (cap_en)
  );

  dbs_span #(.LANES(LANES), .AW(AW)) u_span (
    .cur_i    (cur_a),
    .last_i   (last_a),
    .ack_ni   (pack_ni),
    .ack_vld_o(ack_vld),
    .fin_o    (fin),
    .next_o   (next_a),
    .remain_o (remain),
    .take_o   (take),
    .sel_o    (sel)
  );

  dbs_lanes #(.DW(DW), .LANES(LANES), .AW(AW)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .wdata_i(wdata_i),
    .cur_i  (cur_a),
    .take_i (take & {LANES{cap_en}}),
    .sel_i  (sel),
    .pdata_i(pdata_i),
    .pdata_o(pdata_o),
    .rdata_o(rdata_o)
  );

  assign pa_o   = cur_a;
  assign psiz_o = 2'(remain);
  assign pwr_o  = ~rnw_q;
endmodule

// File: rtl/dbs_bridge_chk.sv
module dbs_bridge_chk #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic [1:0]    pack_ni,
  input logic          pstb_o,
  input logic          ta_o,
  input logic [AW-1:0] pa_o,
  input logic [1:0]    psiz_o,
  input logic [DW-1:0] pdata_o
);
  assert_strobe_needs_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pstb_o) |-> cs_i);

  assert_wait_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstb_o && pack_ni == 2'b11) |=> (pstb_o && $stable(pa_o) && $stable(psiz_o)));

  assert_wdata_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstb_o && pack_ni == 2'b11) |=> $stable(pdata_o));

  assert_gap_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstb_o && pack_ni != 2'b11) |=> !pstb_o);

  assert_ta_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o);

  assert_ta_follows_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ta_o) |-> ($past(pstb_o) && $past(pack_ni) != 2'b11 && !pstb_o));

  assert_quiet_after_ta_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !pstb_o);
endmodule

bind dbs_bridge dbs_bridge_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_i   (cs_i),
  .pack_ni(pack_ni),
  .pstb_o (pstb_o),
  .ta_o   (ta_o),
  .pa_o   (pa_o),
  .psiz_o (psiz_o),
  .pdata_o(pdata_o)
);

// File: tb/dbs_bridge_test.sv
`timescale 1ns/1ps
module dbs_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cs_i;
  logic [1:0]  addr_i;
  logic [1:0]  size_i;
  logic        rnw_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        ta_o;
  logic [1:0]  pa_o;
  logic [1:0]  psiz_o;
  logic        pwr_o;
  logic        pstb_o;
  logic [31:0] pdata_o;
  logic [31:0] pdata_i;
  logic [1:0]  pack_ni;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pmem [4];

  always #2.5 clk_i = ~clk_i;

  dbs_bridge uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int b);
    return w[31-8*b -: 8];
  endfunction

  // R11: size code to last requested byte
  function automatic int last_of(input int a, input int sz);
    int n;
    n = (sz == 1) ? 1 : (sz == 2) ? 2 : 4;
    return (a + n - 1 > 3) ? 3 : a + n - 1;
  endfunction

  function automatic int count_cycles(input int a, input int e, input int p);
    int c, n;
    c = a; n = 0;
    while (c <= e) begin
      n++;
      c = ((c >> p) << p) + (1 << p);
    end
    return n;
  endfunction

  task automatic do_access(input int a, input int sz, input bit rd, input int p, input int maxw);
    int e, cur, ncyc, expn, stall, guard, base, hi;
    logic [31:0] wd, expr;
    logic [7:0] orig [4];
    bit acked, seen;
    e = last_of(a, sz);
    expn = count_cycles(a, e, p);
    for (int k = 0; k < 4; k++) begin
      pmem[k] = 8'($urandom);
      orig[k] = pmem[k];
    end
    wd = $urandom;
    @(negedge clk_i);
    cs_i = 1'b1; addr_i = 2'(a); size_i = 2'(sz); rnw_i = rd; wdata_i = wd;
    cur = a; ncyc = 0; acked = 0; seen = 0; guard = 0;
    stall = $urandom_range(maxw, 0);
    forever begin
      @(negedge clk_i);
      guard++;
      // scrambled after recognition: must be ignored (R6)
      wdata_i = $urandom; addr_i = 2'($urandom); size_i = 2'($urandom); rnw_i = 1'($urandom);
      pack_ni = 2'b11; pdata_i = $urandom;
      if (guard == 1) chk(pstb_o === 1'b1, "R2", "strobe after recognition", 32'(pstb_o), 1);
      if (acked) begin
        chk(pstb_o === 1'b0, "R8", "strobe gap", 32'(pstb_o), 0);
        acked = 0;
      end
      if (ta_o === 1'b1) begin
        chk(ncyc == expn, "R4", "cycle count", ncyc, expn);
        if (rd) begin
          expr = '0;
          for (int b = a; b <= e; b++) expr[31-8*b -: 8] = pmem[b];
          chk(rdata_o === expr, "R5", "assembled read", rdata_o, expr);
        end else begin
          for (int b = 0; b < 4; b++) begin
            if (b >= a && b <= e) chk(pmem[b] === byte_of(wd, b), "R6", "written byte", 32'(pmem[b]), 32'(byte_of(wd, b)));
            else chk(pmem[b] === orig[b], "R6", "untouched byte", 32'(pmem[b]), 32'(orig[b]));
          end
        end
        break;
      end
      if (guard > 60) begin
        chk(1'b0, "R9", "access never acknowledged", 0, 1);
        break;
      end
      if (pstb_o === 1'b1) begin
        if (!seen) begin
          seen = 1;
          chk(pa_o === 2'(cur), "R4", "cycle address", 32'(pa_o), cur);
          chk(psiz_o === 2'(e - cur + 1), "R7", "remaining count", 32'(psiz_o), 32'(2'(e - cur + 1)));
          chk(pwr_o === !rd, "R2", "direction", 32'(pwr_o), 32'(!rd));
          if (!rd) begin
            expr = {byte_of(wd, cur), byte_of(wd, (cur & 2) | 1), byte_of(wd, 2), byte_of(wd, 3)};
            chk(pdata_o === expr, "R6", "write lanes", pdata_o, expr);
          end
        end else begin
          chk(pa_o === 2'(cur), "R3", "address held in wait", 32'(pa_o), cur);
        end
        if (stall > 0) stall--;
        else begin
          pack_ni = (p == 2) ? 2'b00 : (p == 1) ? 2'b01 : 2'b10;
          base = (cur >> p) << p;
          hi = (e < base + (1 << p) - 1) ? e : base + (1 << p) - 1;
          if (rd) begin
            for (int l = 0; l < (1 << p); l++) pdata_i[31-8*l -: 8] = pmem[base + l];
          end else begin
            for (int k = cur; k <= hi; k++) pmem[k] = pdata_o[31-8*(k-base) -: 8];
          end
          cur = base + (1 << p);
          ncyc++;
          acked = 1; seen = 0;
          stall = $urandom_range(maxw, 0);
        end
      end
    end
    @(negedge clk_i);
    pack_ni = 2'b11;
    chk(ta_o === 1'b0, "R9", "acknowledge width", 32'(ta_o), 0);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk_i);
      chk(pstb_o === 1'b0 && ta_o === 1'b0, "R10", "no restart with cs held", {pstb_o, ta_o}, 0);
    end
    cs_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    rst_ni = 1'b0; cs_i = 1'b1; addr_i = '0; size_i = '0; rnw_i = 1'b1;
    wdata_i = '0; pdata_i = '0; pack_ni = 2'b11;
    repeat (3) @(negedge clk_i);
    chk(ta_o === 1'b0, "R1", "ta in reset", 32'(ta_o), 0);
    chk(pstb_o === 1'b0, "R1", "strobe in reset", 32'(pstb_o), 0);
    cs_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pstb_o === 1'b0 && ta_o === 1'b0, "R1", "idle after reset", {pstb_o, ta_o}, 0);
    // directed sweep: every offset, size code (R11), direction and width
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 4; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int rd = 0; rd < 2; rd++)
            do_access(a, sz, 1'(rd), p, (a + sz) % 3);
    // random accesses with longer stalls
    for (int i = 0; i < 200; i++)
      do_access($urandom_range(3, 0), $urandom_range(3, 0), 1'($urandom), $urandom_range(2, 0), 4);
    repeat (2) @(negedge clk_i);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule